// File: doc/BRIEF.md
# Two-Stage Signed Radix-4 Multiplier with Signed-Digit Reduction

This block multiplies two signed two's-complement operands of a configurable width and returns the full double-width product. It sits on the mantissa datapath of a floating-point unit. Exponents, normalization, rounding and flags are handled outside it. The caller raises `in_valid` with an operand pair on any cycle, back to back if it likes. Two clock edges later the product appears with `out_valid` high.

The multiplier operand is recoded into radix-4 digits taken from {-2,-1,0,+1,+2}. Each digit selects zero, the multiplicand or twice the multiplicand, inverted when the digit is negative. Every partial product is widened to the full product width before it is shifted, so all of them share one width. Pairs of partial products become signed-digit operands: one partial product forms the plus vector and the bitwise inverse of the other forms the minus vector. All the two's-complement "+1" terms and the per-pair offsets are collected in one extra correction operand.

A balanced tree of signed-digit adders reduces these operands. In each adder a carry travels at most one position, so the delay does not depend on the width. The tree output is registered. The second stage subtracts the minus vector from the plus vector to give the binary product, and registers that result.

Top module: `rb_booth_mul`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0.
- R2: For every accepted pair, `product` equals the signed product of `a` and `b`, held in 2·W bits in two's complement.
- R3: A pair accepted at a rising edge with `in_valid` high gives `out_valid` high after the next rising edge, which is a latency of exactly two cycles.
- R4: A new pair is accepted on every cycle. Back-to-back inputs give back-to-back results in the order they were accepted.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low two cycles later. Gaps in the input stream appear unchanged in the output stream.
- R6: Extreme operands produce exact results: the most negative value times itself gives +2^(2W-2), and the most negative value times the most positive gives -(2^(2W-2) - 2^(W-1)).
- R7: Multiplier patterns whose radix-4 digits (bit triplets b[2i+1], b[2i], b[2i-1], with b[-1]=0 and the sign bit extended) cover every value from -2 to +2 give exact products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| a | input | W | Multiplicand, signed |
| b | input | W | Multiplier, signed, radix-4 recoded |
| out_valid | output | 1 | `product` holds a result |
| product | output | 2*W | Signed product |

## Verification
The product assertions assume that `a` and `b` are known values whenever `in_valid` is high. They also assume that reset lasts at least one edge, so that the two-cycle look-back only covers defined inputs. The bench therefore holds `in_valid` low through reset and drives the operands only at falling edges. It also keeps operands defined during idle cycles. The bench's own reference is the widened signed multiply, which applies to any operand values. For that reason the stimulus mixes the fixed corner values and the digit-covering patterns with random pairs, gapped streams and continuous streams.

// File: rtl/rb_booth_mul.sv
module rb_booth_mul #(
  parameter int W = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic             out_valid,
  output logic [2*W-1:0]   product
);
  localparam int L    = 2 * W;
  localparam int D    = (W + 1) / 2;
  localparam int NP   = D / 2;
  localparam int NOPS = (D + 1) / 2 + 1;
  localparam int LV   = $clog2(NOPS);

  // signed-digit add: value (xp-xn)+(yp-yn), result canonical (p&n == 0)
  function automatic logic [2*L-1:0] sd_add(input logic [L-1:0] xp, input logic [L-1:0] xn,
                                            input logic [L-1:0] yp, input logic [L-1:0] yn);
    logic [L-1:0] rp, rn, tp, tn, wp, wn;
    int sum;
    logic low_ok;
    for (int i = 0; i < L; i++) begin
      sum = int'(xp[i]) - int'(xn[i]) + int'(yp[i]) - int'(yn[i]);
      if (i == 0) low_ok = 1'b1;
      else low_ok = !(xn[i-1] && !xp[i-1]) && !(yn[i-1] && !yp[i-1]);
      tp[i] = 1'b0; tn[i] = 1'b0; wp[i] = 1'b0; wn[i] = 1'b0;
      case (sum)
        2:  tp[i] = 1'b1;
        -2: tn[i] = 1'b1;
        1:  if (low_ok) begin tp[i] = 1'b1; wn[i] = 1'b1; end
            else wp[i] = 1'b1;
        -1: if (low_ok) wn[i] = 1'b1;
            else begin tn[i] = 1'b1; wp[i] = 1'b1; end
        default: ;
      endcase
    end
    for (int i = 0; i < L; i++) begin
      sum = int'(wp[i]) - int'(wn[i]);
      if (i > 0) sum = sum + int'(tp[i-1]) - int'(tn[i-1]);
      rp[i] = (sum > 0);
      rn[i] = (sum < 0);
    end
    return {rp, rn};
  endfunction

  logic [L-1:0]   a_ext;
  logic [2*D:0]   b_tri;
  logic [L-1:0]   ops_p [NOPS];
  logic [L-1:0]   ops_n [NOPS];
  logic [L-1:0]   tree_p, tree_n;

  assign a_ext = L'($signed(a));
  assign b_tri = {(2*D)'($signed(b)), 1'b0};

  always_comb begin
    logic [L-1:0] pp [D];
    logic [L-1:0] negvec;
    logic [L-1:0] mag;
    logic [2:0]   trip;
    logic         neg;
    logic [2*L-1:0] r;
    int cnt;
    negvec = '0;
    for (int i = 0; i < D; i++) begin
      trip = b_tri[2*i +: 3];
      neg  = trip[2] & ~(trip[1] & trip[0]);
      if (trip[1] ^ trip[0])                    mag = a_ext;
      else if (trip == 3'b011 || trip == 3'b100) mag = a_ext << 1;
      else                                      mag = '0;
      pp[i] = (neg ? ~mag : mag) << (2 * i);
      negvec[2*i] = neg;
    end
    for (int k = 0; k < NOPS; k++) begin
      ops_p[k] = '0;
      ops_n[k] = '0;
    end
    for (int k = 0; k < NP; k++) begin
      ops_p[k] = pp[2*k];
      ops_n[k] = ~pp[2*k+1];
    end
    if (D % 2 == 1) ops_p[NP] = pp[D-1];
    ops_p[NOPS-1] = negvec;
    ops_n[NOPS-1] = L'(NP);
    cnt = NOPS;
    for (int lv = 0; lv < LV; lv++) begin
      for (int j = 0; j < NOPS; j++) begin
        if (2*j + 1 < cnt) begin
          r = sd_add(ops_p[2*j], ops_n[2*j], ops_p[2*j+1], ops_n[2*j+1]);
          ops_p[j] = r[2*L-1:L];
          ops_n[j] = r[L-1:0];
        end else if (2*j < cnt) begin
          ops_p[j] = ops_p[2*j];
          ops_n[j] = ops_n[2*j];
        end
      end
      cnt = (cnt + 1) / 2;
    end
    tree_p = ops_p[0];
    tree_n = ops_n[0];
  end

  logic [L-1:0] sd_p_q, sd_n_q;
  logic         v1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
    end
    sd_p_q  <= tree_p;
    sd_n_q  <= tree_n;
    product <= sd_p_q - sd_n_q;
  end
endmodule

// File: rtl/rb_booth_mul_chk.sv
module rb_booth_mul_chk #(
  parameter int W = 54
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           out_valid,
  input logic [2*W-1:0] product,
  input logic           v1_q,
  input logic [2*W-1:0] sd_p_q,
  input logic [2*W-1:0] sd_n_q
);
  logic signed [2*W-1:0] ref_full;
  assign ref_full = $signed((2*W)'($signed(a))) * $signed((2*W)'($signed(b)));

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (product == $past(ref_full, 2)));

  assert_sd_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (sd_p_q - sd_n_q == $past(ref_full)));

  assert_sd_canonical_R2: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |-> ((sd_p_q & sd_n_q) == '0));
endmodule

bind rb_booth_mul rb_booth_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .product(product),
  .v1_q(v1_q), .sd_p_q(sd_p_q), .sd_n_q(sd_n_q)
);

// File: tb/rb_booth_mul_test.sv
`timescale 1ns/1ps
module rb_booth_mul_test;
  localparam int W = 54;
  localparam int L = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic out_valid;
  logic [L-1:0] product;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string tag = "R2";
  logic [L-1:0] expq [$];

  always #2.5 clk = ~clk;

  rb_booth_mul #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .product(product)
  );

  function automatic logic [L-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [L-1:0] sx, sy;
    sx = L'($signed(x));
    sy = L'($signed(y));
    return sx * sy;
  endfunction

  task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) check("R5", L'(1), L'(0));
      else check(tag, product, expq.pop_front());
    end
  end

  task automatic push(input logic [W-1:0] x, input logic [W-1:0] y);
    in_valid = 1'b1; a = x; b = y;
    expq.push_back(ref_mul(x, y));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    idle(4);
    check({tag, "_drain"}, L'(expq.size()), L'(0));
  endtask

  task automatic t_reset;
    check("R1", L'(out_valid), L'(0));
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", L'(out_valid), L'(0));
    @(negedge clk);
    check("R1", L'(out_valid), L'(0));
  endtask

  task automatic t_latency;
    tag = "R3";
    push(W'(7), W'(-3));
    in_valid = 1'b0;
    check("R3", L'(out_valid), L'(0));
    @(negedge clk);
    check("R3", L'(out_valid), L'(1));
    @(negedge clk);
    check("R5", L'(out_valid), L'(0));
    drain();
  endtask

  task automatic t_corners;
    logic [W-1:0] mn, mx;
    mn = {1'b1, {(W-1){1'b0}}};
    mx = {1'b0, {(W-1){1'b1}}};
    tag = "R2";
    push('0, mx); push(W'(1), W'(1)); push('1, '1); push('1, W'(5)); push(mx, W'(1));
    tag = "R6";
    idle(3);
    push(mn, mn); push(mn, mx); push(mx, mn); push(mx, mx); push(mn, '1);
    drain();
    check("R6", ref_mul(mn, mn), L'(1) << (L - 2));
  endtask

  task automatic t_digits;
    tag = "R7";
    push(W'(64'h2468ACE13579B), {(W/2){2'b01}});
    push(W'(64'h3FFFF0000FFFF), {(W/2){2'b10}});
    push(W'(-12345), {(W/3){3'b011}});
    push(W'(98765), {(W/3){3'b100}});
    push(W'(64'h1555555555555), {(W/6){6'b110010}});
    push(W'(-1), {(W/2){2'b11}});
    drain();
  endtask

  task automatic t_stream;
    tag = "R4";
    for (int i = 0; i < 200; i++) push(W'({$urandom, $urandom}), W'({$urandom, $urandom}));
    drain();
  endtask

  task automatic t_gaps;
    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 1) idle(1);
      else push(W'({$urandom, $urandom}), W'({$urandom, $urandom}));
    end
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_latency();
    t_corners();
    t_digits();
    t_stream();
    t_gaps();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule